// File: doc/BRIEF.md
# DRAM Wait-State Access Sequencer

This block paces an internal bus master's accesses to a single bank of external DRAM. The master presents a request with a 22-bit halfword address, a direction, and a burst length of one to eight halfwords. The sequencer accepts the request when it is idle and then counts the wait states for each beat. The number of wait states depends on the memory technology selected: 50 ns fast-page, 60 ns fast-page or SDRAM. The sequencer pulses `ready` once per completed beat and ends every access with one idle recovery cycle, which covers the row-cycle time.

All transfers are halfword-sized, and byte-granular access does not exist. When the memory is 8 bits wide, each halfword beat is carried as two byte transfers on consecutive cycles. The even byte address goes first. The beat's `ready` comes with the second byte. The `xfer` strobe and `xaddr` byte address show each individual memory transfer.

Top module: `dram_ws_seq`

## Requirements
- R1: After reset, `busy`, `ready` and `xfer` are 0.
- R2: When `req` is high and `busy` is low at a rising edge, the request is accepted. `busy` is high from the next cycle until the access and its recovery cycle are done. `we`, `addr`, `burst_len`, `mem_type` and `bus8` are sampled only at acceptance.
- R3: Read wait states per beat: the first beat has 2 and later beats have 0, when `mem_type` is 0 (50 ns fast-page), 2 or 3 (SDRAM). A beat lasts its wait states plus one cycle, so a 4-beat read ends in its 6th cycle.
- R4: Write wait states per beat: the first beat has 1 and later beats have 0, for `mem_type` 0, 2 and 3.
- R5: With `mem_type` 1 (60 ns fast-page), beat index k>0 (0-based) has 1 wait state when k is even and 0 when k is odd. The first beat has 2 wait states for a read and 1 for a write.
- R6: `ready` is a one-cycle pulse in the last cycle of each beat. Exactly `burst_len` pulses occur. A `burst_len` of 0 acts as 1 and values above 8 act as 8.
- R7: Each beat addresses halfword `addr+k`, modulo 2^22. `xaddr` is the byte address {halfword, byte bit}. In 16-bit mode, `xfer` equals `ready` and the byte bit is 0.
- R8: With `bus8`=1, each beat is one cycle longer. The cycle before `ready` carries an `xfer` with byte bit 0. The `ready` cycle carries an `xfer` with byte bit 1. The wait-state counts are unchanged.
- R9: The cycle after the final `ready` is a recovery cycle: `busy` is high and `ready` is low. `busy` falls in the following cycle.
- R10: A request held high while `busy` is ignored. It is accepted in the first cycle after recovery, so `busy` is low for exactly one cycle between back-to-back accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, level held by master |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 22 | Halfword start address |
| burst_len | input | 4 | Number of halfword beats (1..8) |
| mem_type | input | 2 | 0 fast-page 50 ns, 1 fast-page 60 ns, 2/3 SDRAM |
| bus8 | input | 1 | Memory data bus is 8 bits wide |
| ready | output | 1 | Beat complete strobe |
| busy | output | 1 | Access or recovery in progress |
| xfer | output | 1 | A memory transfer completes this cycle |
| xaddr | output | 23 | Byte address of the current transfer |

## Verification
Two events can fall in the same cycle. The first is the final `ready` of a burst together with a pending request. The second is the recovery cycle together with that same still-held request. The bench provokes both by holding `req` high for the whole of one burst and then starting a second burst with different parameters. It judges the result by three things. The ready pattern of the first burst must be undisturbed. `busy` must drop for exactly one cycle. The second burst's ready timing and addresses must follow its own parameters, which shows that it was latched at the later acceptance and not while busy.

// File: rtl/dram_ws_seq.sv
module dram_ws_seq #(
  parameter int AW = 22,
  parameter int LW = 4,
  parameter int MAXLEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] burst_len,
  input  logic [1:0]    mem_type,
  input  logic          bus8,
  output logic          ready,
  output logic          busy,
  output logic          xfer,
  output logic [AW:0]   xaddr
);
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REC} st_t;

  st_t           st;
  logic [1:0]    wcnt;
  logic [LW-1:0] beat, lenq;
  logic          half, weq, b8q;
  logic [1:0]    tyq;
  logic [AW-1:0] aq;
  logic          last;

  function automatic logic [1:0] ws_of(input logic w, input logic [1:0] ty,
                                        input logic [LW-1:0] k);
    if (k == '0)                   return w ? 2'd1 : 2'd2;
    else if (ty == 2'd1 && !k[0])  return 2'd1;
    else                           return 2'd0;
  endfunction

  assign busy  = (st != S_IDLE);
  assign xfer  = (st == S_ACT) && (wcnt == 2'd0);
  assign ready = xfer && (!b8q || half);
  assign xaddr = {aq, half};
  assign last  = (beat == lenq - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wcnt <= '0; beat <= '0; lenq <= LW'(1); half <= 1'b0;
      weq <= 1'b0; b8q <= 1'b0; tyq <= '0; aq <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st   <= S_ACT;
          weq  <= we;
          b8q  <= bus8;
          tyq  <= mem_type;
          aq   <= addr;
          beat <= '0;
          half <= 1'b0;
          lenq <= (burst_len == '0) ? LW'(1) :
                  (burst_len > LW'(MAXLEN)) ? LW'(MAXLEN) : burst_len;
          wcnt <= ws_of(we, mem_type, '0);
        end
        S_ACT: begin
          if (wcnt != 2'd0) wcnt <= wcnt - 2'd1;
          else if (b8q && !half) half <= 1'b1;
          else begin
            half <= 1'b0;
            if (last) st <= S_REC;
            else begin
              beat <= beat + LW'(1);
              aq   <= aq + AW'(1);
              wcnt <= ws_of(weq, tyq, beat + LW'(1));
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy |=> busy);
  a_r6_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> busy);
  a_r9_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    ready && last |=> busy && !ready && !xfer ##1 !busy);
  a_r8_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    ready && b8q |-> $past(xfer) && !$past(xaddr[0]) && xaddr[0]);
  a_r7_halfword_lane: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !b8q |-> ready && !xaddr[0]);
  a_r8_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready || !b8q);
endmodule

// File: tb/test_dram_ws_seq.sv
module test_dram_ws_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, bus8 = 1'b0;
  logic [21:0] addr = '0;
  logic [3:0]  burst_len = 4'd1;
  logic [1:0]  mem_type = '0;
  logic        ready, busy, xfer;
  logic [22:0] xaddr;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dram_ws_seq i_dram_ws_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .burst_len(burst_len), .mem_type(mem_type), .bus8(bus8),
    .ready(ready), .busy(busy), .xfer(xfer), .xaddr(xaddr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic run_burst(input string tag, input logic w, input logic [3:0] len,
                           input logic [1:0] ty, input logic b8,
                           input logic [21:0] a, input logic hold);
    int endc[8];
    int t = 0;
    int n = (len == 0) ? 1 : (len > 8 ? 8 : len);
    for (int k = 0; k < n; k++) begin
      int ws;
      ws = (k == 0) ? (w ? 1 : 2) : ((ty == 2'd1 && (k % 2) == 0) ? 1 : 0);
      t += ws + 1 + (b8 ? 1 : 0);
      endc[k] = t;
    end
    we = w; burst_len = len; mem_type = ty; bus8 = b8; addr = a; req = 1'b1;
    @(negedge clk);
    req = hold;
    we = ~w; addr = ~a; bus8 = ~b8; mem_type = ty + 2'd1; burst_len = 4'd3;
    for (int c = 1; c <= t + 2; c++) begin
      logic er, ex, eb;
      int kk;
      er = 1'b0; ex = 1'b0; eb = 1'b0; kk = n - 1;
      for (int k = n - 1; k >= 0; k--) if (endc[k] >= c) kk = k;
      for (int k = 0; k < n; k++) begin
        if (endc[k] == c) begin er = 1'b1; ex = 1'b1; eb = b8; end
        if (b8 && endc[k] - 1 == c) ex = 1'b1;
      end
      chk({tag, " ready"}, ready, er);
      chk({tag, " xfer"}, xfer, ex);
      if (ex) chk({tag, " xaddr R7"}, xaddr, {a + 22'(kk), eb});
      chk({tag, " busy R9"}, busy, (c <= t + 1));
      if (c < t + 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 0);
    chk("R1 xfer", xfer, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);
    run_burst("R3 read fp50 x4", 1'b0, 4'd4, 2'd0, 1'b0, 22'h000100, 1'b0);
    run_burst("R3 read sdram x1", 1'b0, 4'd1, 2'd2, 1'b0, 22'h012345, 1'b0);
    run_burst("R4 write sdram x8", 1'b1, 4'd8, 2'd3, 1'b0, 22'h000010, 1'b0);
    run_burst("R4 write fp50 x3", 1'b1, 4'd3, 2'd0, 1'b0, 22'h2AAAAA, 1'b0);
    run_burst("R5 read fp60 x6", 1'b0, 4'd6, 2'd1, 1'b0, 22'h000200, 1'b0);
    run_burst("R5 write fp60 x5", 1'b1, 4'd5, 2'd1, 1'b0, 22'h000300, 1'b0);
    run_burst("R6 len0 as 1", 1'b0, 4'd0, 2'd0, 1'b0, 22'h000040, 1'b0);
    run_burst("R6 len15 as 8", 1'b1, 4'd15, 2'd2, 1'b0, 22'h000050, 1'b0);
    run_burst("R7 wrap", 1'b0, 4'd3, 2'd0, 1'b0, 22'h3FFFFE, 1'b0);
    run_burst("R8 bus8 read sdram x3", 1'b0, 4'd3, 2'd2, 1'b1, 22'h000400, 1'b0);
    run_burst("R8 bus8 write fp60 x4", 1'b1, 4'd4, 2'd1, 1'b1, 22'h000500, 1'b0);
    run_burst("R10 held first", 1'b0, 4'd2, 2'd0, 1'b0, 22'h000600, 1'b1);
    run_burst("R10 held second", 1'b1, 4'd3, 2'd1, 1'b1, 22'h000700, 1'b0);
    run_burst("R2 idle after", 1'b0, 4'd1, 2'd0, 1'b0, 22'h000800, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule